// File: doc/BRIEF.md
# Adaptive-Step Oscillator Lock Controller

This controller sits in the reference clock domain of an all-digital clock generator. It turns the lead/lag decisions of a phase-frequency detector into a 16-bit delay code for a digitally controlled oscillator. A larger code means more delay, so the oscillator runs slower. After reset the code starts at mid-range. A binary-style search moves it by a step that starts at a quarter of the code range. The step halves each time the detector's decision changes direction. Each new code is announced one cycle early by a pair of clear pulses: one to the oscillator and one to the detector.

Once the step has reached one, the controller averages the code over a fixed window. It loads the mean and raises a sticky lock flag. It then waits in a phase-selection state until the phase search outside the block reports completion. From then on it accepts signed fine-frequency trims, which are added to the code with saturation.

Top module: `dco_lock_ctrl`

## Requirements
- R1: While `rst_ni` is low and after it is released, `code_o` is 32768, `lock_o` is 0, both clear outputs are 0 and `state_o` is 2'b00 (tracking).
- R2: In tracking, a decision with `up_i`=1 and `dn_i`=0 raises the code. A decision with `dn_i`=1 and `up_i`=0 lowers it. The first decision after reset moves the code by 16384.
- R3: The step halves when a decision's direction differs from the previous decision's direction. The halved step applies to that same move. The step is unchanged on a repeated direction and never drops below 1.
- R4: A cycle with `up_i` equal to `dn_i` is no decision. It produces no clear pulse and leaves both the code and the step unchanged.
- R5: Every code update is preceded by a one-cycle pulse on `clr_dco_o` and `clr_pfd_o` together. `code_o` takes its new value at the clock edge that ends the pulse. While a pulse is high, new decisions and trims are not taken.
- R6: Search moves saturate at 0 and 65535.
- R7: The move that brings the step to 1 switches `state_o` to 2'b01 (averaging). Decisions keep moving the code by 1 there.
- R8: In averaging, the code is sampled on each clock edge at which no clear pulse is high. When the 8th sample is taken, the floor of the mean of the 8 samples is loaded through a clear pulse. `lock_o` rises at the edge that starts that pulse, `state_o` becomes 2'b10 (phase selection), and `lock_o` then stays high until reset.
- R9: In phase selection, detector decisions are ignored and the code holds. A high `phase_done_i` moves `state_o` to 2'b11 (trimming).
- R10: In trimming, `tune_valid_i` adds `tune_code_i`, read as two's complement, to the code through a clear pulse, with saturation at 0 and 65535. The block stays in trimming until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| up_i | input | 1 | Detector: feedback leads, slow down |
| dn_i | input | 1 | Detector: feedback lags, speed up |
| phase_done_i | input | 1 | Phase search finished |
| tune_valid_i | input | 1 | Trim qualifier |
| tune_code_i | input | 16 | Signed frequency trim |
| code_o | output | 16 | Oscillator delay code |
| clr_dco_o | output | 1 | Oscillator clear pulse |
| clr_pfd_o | output | 1 | Detector clear pulse |
| lock_o | output | 1 | Frequency lock flag |
| state_o | output | 2 | Controller state |

## Verification
A wrong step register shows within two cycles of the next decision, because the code moves by the wrong amount. The directed search sequences therefore compare every move against an independently tracked step. A wrong direction memory shows as a missed or extra halving, again at the next move. A fault in the averaging counter or sum shows only at lock: the lock edge arrives too early or too late, or the loaded code differs from the mean. The bench checks both the number of cycles to lock and the loaded value after a varied code sequence.

// File: rtl/dco_lock_pkg.sv
package dco_lock_pkg;
  typedef enum logic [1:0] {
    ST_TRACK = 2'b00,
    ST_AVG   = 2'b01,
    ST_PHASE = 2'b10,
    ST_TRIM  = 2'b11
  } lock_state_e;
endpackage

// File: rtl/dco_search_step.sv
module dco_search_step #(
  parameter int CODE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dec_valid_i,
  input  logic              dec_up_i,
  output logic [CODE_W-1:0] step_o
);
  localparam logic [CODE_W-1:0] STEP_INIT = {2'b01, {(CODE_W-2){1'b0}}};
  localparam logic [CODE_W-1:0] STEP_ONE  = {{(CODE_W-1){1'b0}}, 1'b1};

  logic [CODE_W-1:0] step_q;
  logic              have_dir_q, last_up_q;
  logic              reversal;

  assign reversal = have_dir_q && (last_up_q != dec_up_i);
  // step used by the current move
  assign step_o = (reversal && step_q > STEP_ONE) ? (step_q >> 1) : step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q     <= STEP_INIT;
      have_dir_q <= 1'b0;
      last_up_q  <= 1'b0;
    end else if (dec_valid_i) begin
      step_q     <= step_o;
      have_dir_q <= 1'b1;
      last_up_q  <= dec_up_i;
    end
  end
endmodule

// File: rtl/dco_sat_adder.sv
module dco_sat_adder #(
  parameter int CODE_W = 16
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W:0]   off_i,
  output logic [CODE_W-1:0] code_o
);
  logic signed [CODE_W+1:0] sum;

  assign sum = $signed({2'b00, code_i}) + $signed({off_i[CODE_W], off_i});

  always_comb begin
    if (sum[CODE_W+1])   code_o = '0;
    else if (sum[CODE_W]) code_o = '1;
    else                  code_o = sum[CODE_W-1:0];
  end
endmodule

// File: rtl/dco_code_avg.sv
module dco_code_avg #(
  parameter int CODE_W   = 16,
  parameter int AVG_LOG2 = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              done_o,
  output logic [CODE_W-1:0] avg_o
);
  localparam int SUM_W = CODE_W + AVG_LOG2;
  localparam logic [AVG_LOG2-1:0] CNT_ONE = {{(AVG_LOG2-1){1'b0}}, 1'b1};

  logic [AVG_LOG2-1:0] cnt_q;
  logic [SUM_W-1:0]    sum_q, total;

  assign total  = sum_q + {{AVG_LOG2{1'b0}}, code_i};
  assign done_o = sample_i && (cnt_q == '1);
  assign avg_o  = total[SUM_W-1 -: CODE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sum_q <= '0;
    end else if (sample_i) begin
      if (done_o) begin
        cnt_q <= '0;
        sum_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_ONE;
        sum_q <= total;
      end
    end
  end
endmodule

// File: rtl/dco_lock_ctrl.sv
module dco_lock_ctrl
  import dco_lock_pkg::*;
#(
  parameter int CODE_W   = 16,
  parameter int TRIM_W   = 16,
  parameter int AVG_LOG2 = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_i,
  input  logic              dn_i,
  input  logic              phase_done_i,
  input  logic              tune_valid_i,
  input  logic [TRIM_W-1:0] tune_code_i,
  output logic [CODE_W-1:0] code_o,
  output logic              clr_dco_o,
  output logic              clr_pfd_o,
  output logic              lock_o,
  output logic [1:0]        state_o
);
  localparam logic [CODE_W-1:0] CODE_MID = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] STEP_ONE = {{(CODE_W-1){1'b0}}, 1'b1};
  localparam int EXT_W = CODE_W + 1 - TRIM_W;

  lock_state_e       state_q;
  logic [CODE_W-1:0] code_q, next_q;
  logic              pend_q, lock_q;

  logic              searching, dec_valid, avg_sample, avg_done, trim_take;
  logic [CODE_W-1:0] step_use, avg_code, sat_code;
  logic [CODE_W:0]   step_off, trim_off, off;

  assign searching  = (state_q == ST_TRACK) || (state_q == ST_AVG);
  assign avg_sample = (state_q == ST_AVG) && !pend_q;
  assign dec_valid  = searching && !pend_q && (up_i ^ dn_i) && !avg_done;
  assign trim_take  = (state_q == ST_TRIM) && !pend_q && tune_valid_i;

  dco_search_step #(.CODE_W(CODE_W)) u_step (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dec_valid_i (dec_valid),
    .dec_up_i    (up_i),
    .step_o      (step_use)
  );

  dco_code_avg #(.CODE_W(CODE_W), .AVG_LOG2(AVG_LOG2)) u_avg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (avg_sample),
    .code_i   (code_q),
    .done_o   (avg_done),
    .avg_o    (avg_code)
  );

  assign step_off = up_i ? {1'b0, step_use} : -{1'b0, step_use};
  assign trim_off = {{EXT_W{tune_code_i[TRIM_W-1]}}, tune_code_i};
  assign off      = trim_take ? trim_off : step_off;

  dco_sat_adder #(.CODE_W(CODE_W)) u_add (
    .code_i (code_q),
    .off_i  (off),
    .code_o (sat_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_TRACK;
      code_q  <= CODE_MID;
      next_q  <= CODE_MID;
      pend_q  <= 1'b0;
      lock_q  <= 1'b0;
    end else if (pend_q) begin
      code_q <= next_q;
      pend_q <= 1'b0;
    end else if (avg_done) begin
      next_q  <= avg_code;
      pend_q  <= 1'b1;
      lock_q  <= 1'b1;
      state_q <= ST_PHASE;
    end else if (dec_valid) begin
      next_q <= sat_code;
      pend_q <= 1'b1;
      if (state_q == ST_TRACK && step_use == STEP_ONE) state_q <= ST_AVG;
    end else if (trim_take) begin
      next_q <= sat_code;
      pend_q <= 1'b1;
    end else if (state_q == ST_PHASE && phase_done_i) begin
      state_q <= ST_TRIM;
    end
  end

  assign code_o    = code_q;
  assign clr_dco_o = pend_q;
  assign clr_pfd_o = pend_q;
  assign lock_o    = lock_q;
  assign state_o   = state_q;
endmodule

// File: rtl/dco_lock_ctrl_chk.sv
module dco_lock_ctrl_chk #(
  parameter int CODE_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              up_i,
  input logic              dn_i,
  input logic [CODE_W-1:0] code_o,
  input logic              clr_dco_o,
  input logic              clr_pfd_o,
  input logic              lock_o,
  input logic [1:0]        state_o
);
  a_r5_clear_before_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> $past(clr_dco_o) && $past(clr_pfd_o));

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_dco_o |=> !clr_dco_o);

  a_r4_idle_no_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b00 && !clr_dco_o && up_i == dn_i) |=> !clr_dco_o);

  a_r8_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> lock_o);

  a_r8_lock_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> state_o[1]);

  a_r9_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b10 && !clr_dco_o) |=> $stable(code_o));

  a_r10_trim_terminal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'b11 |=> state_o == 2'b11);
endmodule

bind dco_lock_ctrl dco_lock_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .up_i      (up_i),
  .dn_i      (dn_i),
  .code_o    (code_o),
  .clr_dco_o (clr_dco_o),
  .clr_pfd_o (clr_pfd_o),
  .lock_o    (lock_o),
  .state_o   (state_o)
);

// File: tb/dco_lock_ctrl_tb.sv
module dco_lock_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        up_i = 1'b0, dn_i = 1'b0, phase_done_i = 1'b0, tune_valid_i = 1'b0;
  logic [15:0] tune_code_i = '0;
  logic [15:0] code_o;
  logic        clr_dco_o, clr_pfd_o, lock_o;
  logic [1:0]  state_o;

  int checks = 0, failures = 0;
  int m_code, m_step;
  bit m_have, m_last_up;

  always #(CLK_PERIOD/2) clk = ~clk;

  dco_lock_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .up_i(up_i), .dn_i(dn_i),
    .phase_done_i(phase_done_i), .tune_valid_i(tune_valid_i), .tune_code_i(tune_code_i),
    .code_o(code_o), .clr_dco_o(clr_dco_o), .clr_pfd_o(clr_pfd_o),
    .lock_o(lock_o), .state_o(state_o)
  );

  function automatic int sat(input int v);
    if (v < 0) return 0;
    if (v > 65535) return 65535;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; up_i = 0; dn_i = 0; phase_done_i = 0; tune_valid_i = 0;
    repeat (3) @(negedge clk);
    chk(code_o == 16'd32768, "R1 code in reset", int'(code_o), 32768);
    rst_ni = 1'b1;
    @(negedge clk);
    m_code = 32768; m_step = 16384; m_have = 0; m_last_up = 0;
  endtask

  // one detector decision; entered and left at a falling edge
  task automatic decide(input bit up, input string req);
    int old_code = m_code;
    if (m_have && m_last_up != up && m_step > 1) m_step = m_step / 2;
    m_code = sat(up ? m_code + m_step : m_code - m_step);
    m_have = 1; m_last_up = up;
    up_i = up; dn_i = !up;
    @(negedge clk);
    up_i = 0; dn_i = 0;
    chk(clr_dco_o && clr_pfd_o, {req, " R5 clear pulse"}, int'(clr_dco_o), 1);
    chk(code_o == 16'(old_code), {req, " R5 code held during clear"}, int'(code_o), old_code);
    @(negedge clk);
    chk(!clr_dco_o && !clr_pfd_o, {req, " R5 clear ends"}, int'(clr_dco_o), 0);
    chk(code_o == 16'(m_code), {req, " code after move"}, int'(code_o), m_code);
  endtask

  task automatic trim(input int t);
    m_code = sat(m_code + t);
    tune_valid_i = 1; tune_code_i = 16'(t);
    @(negedge clk);
    tune_valid_i = 0;
    chk(clr_dco_o == 1'b1, "R10 trim clear", int'(clr_dco_o), 1);
    @(negedge clk);
    chk(code_o == 16'(m_code), "R10 trim result", int'(code_o), m_code);
  endtask

  task automatic t_reset();
    do_reset();
    chk(code_o == 16'd32768, "R1 code mid", int'(code_o), 32768);
    chk(state_o == 2'b00, "R1 state", int'(state_o), 0);
    chk(!lock_o && !clr_dco_o && !clr_pfd_o, "R1 flags", int'(lock_o), 0);
  endtask

  task automatic t_sat_low();
    do_reset();
    decide(0, "R2 first down");
    decide(0, "R6 down to zero");
    decide(0, "R6 floor held");
  endtask

  task automatic t_no_decision();
    do_reset();
    up_i = 1; dn_i = 1;
    @(negedge clk);
    chk(!clr_dco_o, "R4 no clear on both high", int'(clr_dco_o), 0);
    up_i = 0; dn_i = 0;
    @(negedge clk);
    chk(code_o == 16'd32768, "R4 code unchanged", int'(code_o), 32768);
    decide(1, "R4 step unchanged");
    decide(0, "R3 halve on reversal");
  endtask

  task automatic t_main();
    int c_entry, exp_avg, waited;
    bit dir;
    do_reset();
    decide(1, "R2 up");
    decide(1, "R6 up saturates");
    decide(0, "R3 reversal");
    decide(0, "R3 repeat keeps step");
    dir = 1;
    for (int i = 0; i < 20 && m_step > 1; i++) begin
      decide(dir, "R3 search");
      dir = !dir;
    end
    chk(state_o == 2'b01, "R7 averaging entered", int'(state_o), 1);
    c_entry = m_code;
    decide(!m_last_up, "R3 R7 step floor one");
    decide(1, "R7 move by one");
    decide(1, "R7 move by one again");
    exp_avg = (c_entry + (c_entry - 1) + c_entry + 5 * (c_entry + 1)) / 8;
    waited = 0;
    while (!lock_o && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    chk(waited == 5, "R8 lock after eighth sample", waited, 5);
    chk(state_o == 2'b10 && clr_dco_o, "R8 phase state with clear", int'(state_o), 2);
    @(negedge clk);
    chk(code_o == 16'(exp_avg), "R8 averaged code", int'(code_o), exp_avg);
    m_code = exp_avg;
    up_i = 1;
    repeat (2) @(negedge clk);
    up_i = 0;
    chk(!clr_dco_o && code_o == 16'(exp_avg), "R9 decision ignored", int'(code_o), exp_avg);
    chk(state_o == 2'b10 && lock_o, "R9 stays in phase", int'(state_o), 2);
    phase_done_i = 1;
    @(negedge clk);
    phase_done_i = 0;
    chk(state_o == 2'b11, "R9 to trimming", int'(state_o), 3);
    trim(5);
    trim(-100);
    trim(32767);
    trim(-32768);
    trim(-32768);
    chk(lock_o == 1'b1 && state_o == 2'b11, "R8 R10 lock held", int'(lock_o), 1);
  endtask

  initial begin
    t_reset();
    t_sat_low();
    t_no_decision();
    t_main();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule